// File: doc/BRIEF.md
# Low-Power Mode Transition Controller

This block tracks which power mode a processor is in and decides the next one. Five modes exist: full-speed, low-speed run on the subclock, low-speed sleep, watch and hardware standby. A sleep strobe from the core, qualified by four mode-control bits, moves the controller into a lower-power mode. An accepted interrupt moves it out of a sleeping mode. A standby pin forces hardware standby from any mode. A reset pin returns the controller to full speed.

From the current mode the block derives a CPU clock enable, a main-clock/subclock select and a peripheral-stop signal. Both watchdogs stay outside that stop. On every interrupt wake the block emits a one-cycle exception-start pulse. It also passes the main-clock divider select through, holding it at zero during low-speed run and flagging an error when the divider was nonzero on entry. All inputs are sampled on the rising clock edge. The reset pin is an asynchronous, active-low reset of the block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rstN` is low, `mode` is 0 (full-speed), `cpuClkEn`=1, `subClkSel`=0, `periphStop`=0, `irqStart`=0 and `divErr`=0.
- R2: In full-speed (0), a sleep strobe with standby=1, direct=1, lowSpeed=1 and prescale=1 moves `mode` to low-speed run (1) at that clock edge.
- R3: In low-speed run (1), a sleep strobe with standby=0, lowSpeed=1 and prescale=1 moves `mode` to low-speed sleep (2). The direct bit is ignored for this transition.
- R4: In full-speed or low-speed run, a sleep strobe with standby=1, direct=0 and prescale=1 moves `mode` to watch (3), whatever the value of lowSpeed.
- R5: In low-speed sleep, an accepted interrupt moves `mode` to low-speed run. `irqStart` is then high for exactly the first cycle in the new mode.
- R6: An interrupt is accepted when `nmi`=1, when any `irqReq[i]` has `irqEn[i]`=1, or when any `periphReq[j]` has `periphEn[j]`=1 while `cpuMask`=0. Any other request leaves the mode unchanged and gives no pulse.
- R7: In watch, an accepted interrupt moves `mode` to low-speed run if lowSpeed=1, and to full-speed if lowSpeed=0. Either way `irqStart` pulses.
- R8: Low-speed run is not left by any interrupt. It is left only by a sleep strobe, the standby pin or reset.
- R9: `stbyN` low at an edge moves `mode` to hardware standby (4) from any mode. This takes priority over a sleep strobe and over a wake, and no pulse is produced. Hardware standby persists after `stbyN` returns high, until `rstN` is asserted.
- R10: `cpuClkEn`=1 only in modes 0 and 1. `subClkSel`=1 only in modes 1, 2 and 3. `periphStop`=1 in every mode except 0.
- R11: `divSelOut` equals `divSelIn` except in mode 1, where it is 0. If `divSelIn` is nonzero at the edge that enters mode 1, `divErr` is high for the whole stay in mode 1. Otherwise `divErr` is low.
- R12: A sleep strobe whose bit combination matches no defined transition leaves the mode unchanged. So does any sleep strobe in modes 2, 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Reset pin, active low, asynchronous |
| stbyN | input | 1 | Standby pin, active low |
| sleepExec | input | 1 | Sleep instruction executed strobe |
| ctlStandby | input | 1 | Standby-select control bit |
| ctlDirect | input | 1 | Direct-transfer control bit |
| ctlLowSpeed | input | 1 | Low-speed-on control bit |
| ctlPrescale | input | 1 | Watchdog prescaler-select control bit |
| irqReq | input | NUM_IRQ | External interrupt request lines |
| irqEn | input | NUM_IRQ | External interrupt enables |
| periphReq | input | NUM_PERIPH | Peripheral interrupt requests |
| periphEn | input | NUM_PERIPH | Peripheral interrupt enables |
| cpuMask | input | 1 | CPU global mask for peripheral interrupts |
| nmi | input | 1 | Non-maskable interrupt |
| divSelIn | input | DIV_W | Requested main-clock divider select |
| mode | output | 3 | Current mode (0 full, 1 low run, 2 low sleep, 3 watch, 4 hw standby) |
| cpuClkEn | output | 1 | CPU clock enable |
| subClkSel | output | 1 | 1 selects the subclock |
| periphStop | output | 1 | Stop for all peripherals other than the watchdogs |
| irqStart | output | 1 | Interrupt exception start pulse |
| divSelOut | output | DIV_W | Divider select after clamping |
| divErr | output | 1 | Divider was nonzero on entry to low-speed run |

## Verification
Two functions can fall into the same cycle. A wake from low-speed sleep can coincide with the standby pin going low. A sleep strobe in low-speed run can coincide with an enabled interrupt. The bench drives both pairs in a single cycle. For the first pair it expects hardware standby with no exception pulse. For the second it expects the sleep transition to win. Separate cycles check that masked or disabled requests do not wake the block.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    MODE_FULL    = 3'd0,
    MODE_LOWRUN  = 3'd1,
    MODE_LOWSLP  = 3'd2,
    MODE_WATCH   = 3'd3,
    MODE_HWSTBY  = 3'd4
  } pwrMode_e;

  typedef struct packed {
    logic wakeTaken;
    logic enterLowRun;
    logic stayLowRun;
  } ctlStrobe_t;
endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stbyN,
  input  logic       sleepExec,
  input  logic       ctlStandby,
  input  logic       ctlDirect,
  input  logic       ctlLowSpeed,
  input  logic       ctlPrescale,
  input  logic       wakeOk,
  output pwrMode_e   curMode,
  output ctlStrobe_t strobe
);
  pwrMode_e nextMode;

  always_comb begin
    nextMode = curMode;
    strobe   = '0;
    if (!stbyN) begin
      nextMode = MODE_HWSTBY;
    end else begin
      unique case (curMode)
        MODE_FULL: begin
          if (sleepExec && ctlStandby && ctlPrescale) begin
            if (ctlDirect && ctlLowSpeed) begin
              nextMode           = MODE_LOWRUN;
              strobe.enterLowRun = 1'b1;
            end else if (!ctlDirect) begin
              nextMode = MODE_WATCH;
            end
          end
        end
        MODE_LOWRUN: begin
          if (sleepExec && ctlPrescale && !ctlStandby && ctlLowSpeed)
            nextMode = MODE_LOWSLP;
          else if (sleepExec && ctlPrescale && ctlStandby && !ctlDirect)
            nextMode = MODE_WATCH;
          else
            strobe.stayLowRun = 1'b1;
        end
        MODE_LOWSLP: begin
          if (wakeOk) begin
            nextMode           = MODE_LOWRUN;
            strobe.wakeTaken   = 1'b1;
            strobe.enterLowRun = 1'b1;
          end
        end
        MODE_WATCH: begin
          if (wakeOk) begin
            nextMode           = ctlLowSpeed ? MODE_LOWRUN : MODE_FULL;
            strobe.wakeTaken   = 1'b1;
            strobe.enterLowRun = ctlLowSpeed;
          end
        end
        default: nextMode = MODE_HWSTBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curMode <= MODE_FULL;
    else       curMode <= nextMode;
  end

  // R9: standby pin dominates everything
  a_r9_standby_forces: assert property (@(posedge clk) disable iff (!rstN)
    !stbyN |=> curMode == MODE_HWSTBY);
  // R9: hardware standby is held until reset
  a_r9_standby_holds: assert property (@(posedge clk) disable iff (!rstN)
    curMode == MODE_HWSTBY |=> curMode == MODE_HWSTBY);
  // R8: low-speed run ignores interrupts
  a_r8_lowrun_exit: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_LOWRUN && !sleepExec && stbyN) |=> curMode == MODE_LOWRUN);
  // R12: sleeping modes ignore the sleep strobe absent a wake
  a_r12_sleep_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_LOWSLP && !wakeOk && stbyN) |=> curMode == MODE_LOWSLP);
endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
#(
  parameter int NUM_IRQ    = 6,
  parameter int NUM_PERIPH = 4,
  parameter int DIV_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pwrMode_e              curMode,
  input  ctlStrobe_t            strobe,
  input  logic [NUM_IRQ-1:0]    irqReq,
  input  logic [NUM_IRQ-1:0]    irqEn,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_PERIPH-1:0] periphEn,
  input  logic                  cpuMask,
  input  logic                  nmi,
  input  logic [DIV_W-1:0]      divSelIn,
  output logic                  wakeOk,
  output logic                  cpuClkEn,
  output logic                  subClkSel,
  output logic                  periphStop,
  output logic                  irqStart,
  output logic [DIV_W-1:0]      divSelOut,
  output logic                  divErr
);
  logic [NUM_IRQ-1:0]    irqHit;
  logic [NUM_PERIPH-1:0] periphHit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      assign irqHit[gi] = irqReq[gi] & irqEn[gi];
    end
    for (gi = 0; gi < NUM_PERIPH; gi++) begin : g_per
      assign periphHit[gi] = periphReq[gi] & periphEn[gi] & ~cpuMask;
    end
  endgenerate

  assign wakeOk = nmi | (|irqHit) | (|periphHit);

  always_comb begin
    cpuClkEn   = (curMode == MODE_FULL) || (curMode == MODE_LOWRUN);
    subClkSel  = (curMode == MODE_LOWRUN) || (curMode == MODE_LOWSLP) ||
                 (curMode == MODE_WATCH);
    periphStop = (curMode != MODE_FULL);
    divSelOut  = (curMode == MODE_LOWRUN) ? '0 : divSelIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqStart <= 1'b0;
      divErr   <= 1'b0;
    end else begin
      irqStart <= strobe.wakeTaken;
      if (strobe.enterLowRun)     divErr <= |divSelIn;
      else if (!strobe.stayLowRun) divErr <= 1'b0;
    end
  end

  // R5: exception start is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqStart |=> !irqStart);
  // R5/R7: a pulse only follows a sleeping mode
  a_r7_pulse_origin: assert property (@(posedge clk) disable iff (!rstN)
    irqStart |-> ($past(curMode) == MODE_LOWSLP || $past(curMode) == MODE_WATCH));
  // R11: error flag lives only inside low-speed run
  a_r11_err_scope: assert property (@(posedge clk) disable iff (!rstN)
    divErr |-> curMode == MODE_LOWRUN);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_IRQ    = 6,
  parameter int NUM_PERIPH = 4,
  parameter int DIV_W      = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  stbyN,
  input  logic                  sleepExec,
  input  logic                  ctlStandby,
  input  logic                  ctlDirect,
  input  logic                  ctlLowSpeed,
  input  logic                  ctlPrescale,
  input  logic [NUM_IRQ-1:0]    irqReq,
  input  logic [NUM_IRQ-1:0]    irqEn,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_PERIPH-1:0] periphEn,
  input  logic                  cpuMask,
  input  logic                  nmi,
  input  logic [DIV_W-1:0]      divSelIn,
  output logic [2:0]            mode,
  output logic                  cpuClkEn,
  output logic                  subClkSel,
  output logic                  periphStop,
  output logic                  irqStart,
  output logic [DIV_W-1:0]      divSelOut,
  output logic                  divErr
);
  pwrMode_e   curMode;
  ctlStrobe_t strobe;
  logic       wakeOk;

  pwr_mode_fsm u_fsm (
    .clk(clk), .rstN(rstN), .stbyN(stbyN), .sleepExec(sleepExec),
    .ctlStandby(ctlStandby), .ctlDirect(ctlDirect),
    .ctlLowSpeed(ctlLowSpeed), .ctlPrescale(ctlPrescale),
    .wakeOk(wakeOk), .curMode(curMode), .strobe(strobe)
  );

  pwr_mode_dp #(.NUM_IRQ(NUM_IRQ), .NUM_PERIPH(NUM_PERIPH), .DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .curMode(curMode), .strobe(strobe),
    .irqReq(irqReq), .irqEn(irqEn), .periphReq(periphReq),
    .periphEn(periphEn), .cpuMask(cpuMask), .nmi(nmi),
    .divSelIn(divSelIn), .wakeOk(wakeOk), .cpuClkEn(cpuClkEn),
    .subClkSel(subClkSel), .periphStop(periphStop), .irqStart(irqStart),
    .divSelOut(divSelOut), .divErr(divErr)
  );

  assign mode = curMode;
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rstN, stbyN, sleepExec, ctlStandby, ctlDirect, ctlLowSpeed, ctlPrescale;
  logic [5:0] irqReq, irqEn;
  logic [3:0] periphReq, periphEn;
  logic cpuMask, nmi;
  logic [1:0] divSelIn;
  logic [2:0] mode;
  logic cpuClkEn, subClkSel, periphStop, irqStart, divErr;
  logic [1:0] divSelOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  typedef struct {
    logic [2:0] m;
    logic       pulse;
    logic       err;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .stbyN(stbyN), .sleepExec(sleepExec),
    .ctlStandby(ctlStandby), .ctlDirect(ctlDirect), .ctlLowSpeed(ctlLowSpeed),
    .ctlPrescale(ctlPrescale), .irqReq(irqReq), .irqEn(irqEn),
    .periphReq(periphReq), .periphEn(periphEn), .cpuMask(cpuMask), .nmi(nmi),
    .divSelIn(divSelIn), .mode(mode), .cpuClkEn(cpuClkEn), .subClkSel(subClkSel),
    .periphStop(periphStop), .irqStart(irqStart), .divSelOut(divSelOut),
    .divErr(divErr)
  );

  task automatic checkNow(input logic [2:0] m, input logic pulse, input logic err,
                          input string tag);
    logic eClk, eSub, eStop;
    logic [1:0] eDiv;
    eClk  = (m == 3'd0) || (m == 3'd1);
    eSub  = (m == 3'd1) || (m == 3'd2) || (m == 3'd3);
    eStop = (m != 3'd0);
    eDiv  = (m == 3'd1) ? 2'd0 : divSelIn;
    total++;
    if (mode !== m || irqStart !== pulse || divErr !== err || cpuClkEn !== eClk ||
        subClkSel !== eSub || periphStop !== eStop || divSelOut !== eDiv) begin
      bad++;
      $display("FAIL %s: got mode=%0d irq=%b err=%b clk=%b sub=%b stop=%b div=%0d exp mode=%0d irq=%b err=%b clk=%b sub=%b stop=%b div=%0d",
               tag, mode, irqStart, divErr, cpuClkEn, subClkSel, periphStop, divSelOut,
               m, pulse, err, eClk, eSub, eStop, eDiv);
    end
  endtask

  // Driver: inputs already set at a falling edge; push expectation, wait a cycle
  task automatic step(input logic [2:0] m, input logic pulse, input logic err,
                      input string tag);
    exp_t e;
    e.m = m; e.pulse = pulse; e.err = err; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    sleepExec = 0; irqReq = '0; periphReq = '0; nmi = 0;
  endtask

  task automatic setCtl(input logic s, input logic d, input logic l, input logic p);
    ctlStandby = s; ctlDirect = d; ctlLowSpeed = l; ctlPrescale = p;
  endtask

  // Monitor: pops and compares shortly after each rising edge
  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checkNow(e.m, e.pulse, e.err, e.tag);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++; total++;
      $display("FAIL watchdog: got running exp finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 0; stbyN = 1; sleepExec = 0; setCtl(0, 0, 0, 0);
    irqReq = '0; irqEn = '0; periphReq = '0; periphEn = '0;
    cpuMask = 0; nmi = 0; divSelIn = 2'd0;
    repeat (3) @(negedge clk);
    checkNow(3'd0, 0, 0, "R1 reset state");
    rstN = 1;
    step(3'd0, 0, 0, "R1 idle after reset");
    sleepExec = 1; setCtl(0, 1, 1, 1);
    step(3'd0, 0, 0, "R12 undefined combo in full");
    sleepExec = 1; setCtl(1, 1, 1, 0);
    step(3'd0, 0, 0, "R12 prescale=0 ignored");
    sleepExec = 1; setCtl(1, 1, 1, 1); divSelIn = 2'd2;
    step(3'd1, 0, 1, "R2 R11 full to low run with divider error");
    irqReq = 6'h01; irqEn = 6'h3F; nmi = 1;
    step(3'd1, 0, 1, "R8 interrupts do not leave low run");
    sleepExec = 1; setCtl(1, 1, 1, 1);
    step(3'd1, 0, 1, "R12 undefined combo in low run");
    sleepExec = 1; setCtl(0, 1, 1, 1); irqReq = 6'h02;
    step(3'd2, 0, 0, "R3 sleep wins over interrupt, R10 low sleep");
    irqReq = 6'h08; irqEn = 6'h37;
    step(3'd2, 0, 0, "R6 disabled irq line");
    periphReq = 4'h4; periphEn = 4'hF; cpuMask = 1;
    step(3'd2, 0, 0, "R6 masked peripheral");
    sleepExec = 1; setCtl(1, 1, 1, 1); divSelIn = 2'd0;
    step(3'd2, 0, 0, "R12 sleep in low sleep ignored");
    periphReq = 4'h4; cpuMask = 0;
    step(3'd1, 1, 0, "R5 peripheral wake to low run");
    step(3'd1, 0, 0, "R5 pulse lasts one cycle");
    sleepExec = 1; setCtl(1, 0, 0, 1);
    step(3'd3, 0, 0, "R4 low run to watch");
    nmi = 1; setCtl(1, 0, 0, 1);
    step(3'd0, 1, 0, "R7 watch nmi lowSpeed=0 to full");
    sleepExec = 1; setCtl(1, 0, 1, 1);
    step(3'd3, 0, 0, "R4 full to watch");
    irqReq = 6'h20; irqEn = 6'h20; setCtl(0, 0, 1, 1); divSelIn = 2'd1;
    step(3'd1, 1, 1, "R7 R11 watch to low run with divider error");
    sleepExec = 1; setCtl(0, 0, 1, 1);
    step(3'd2, 0, 0, "R3 direct bit ignored");
    nmi = 1; stbyN = 0;
    step(3'd4, 0, 0, "R9 standby beats wake");
    stbyN = 1;
    step(3'd4, 0, 0, "R9 standby held after pin release");
    sleepExec = 1; setCtl(1, 1, 1, 1); nmi = 1;
    step(3'd4, 0, 0, "R12 R9 no exit without reset");
    rstN = 0; divSelIn = 2'd3;
    #1;
    checkNow(3'd0, 0, 0, "R1 reset from standby");
    @(negedge clk);
    rstN = 1;
    step(3'd0, 0, 0, "R11 divider passes in full");
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule